// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line priority controllers, a primary and a secondary, into one interrupt source for a processor. The secondary controller's request is folded into the primary through primary line 2, which is fed from an internal pulse rather than from the external pin. The processor interrupt output follows the primary's resolver. When the processor strobes an acknowledge, the block picks the winning line, updates the in-service and request state of the controller or controllers involved, and returns an 8-bit vector one cycle later.

Each controller keeps its own request latches, mask, per-line trigger mode, vector base, rotation base and automatic end-of-interrupt options. The vector is the upper five bits of the owning controller's base joined with the three-bit line number. Acknowledges with no valid winner return line 7 of the relevant controller as a spurious vector.

Top module: `irqc_cascade_ack`

## Requirements
- R1: After reset, cpu_int, ack_valid, ack_vector and all request and in-service bits are 0, and both rotation bases are 0.
- R2: A line whose trigger bit is 0 latches its request bit on a rising edge of the line, and the bit stays set until an acknowledge clears it. A line whose trigger bit is 1 has its request bit follow the line level. A mask bit of 1 leaves latching unchanged but keeps that line out of resolution.
- R3: cpu_int is 1 exactly when the primary has an unmasked pending line whose priority is strictly higher than that of every line in service. Priority starts at the rotation base (highest) and falls with increasing line number modulo 8.
- R4: ack_valid is 1 in the cycle after each cycle with ack_req at 1, and 0 otherwise. The winning line's in-service bit is set. Its request bit is cleared only if the line is edge-triggered.
- R5: A vector is the base's bits 7:3 followed by a 3-bit line number, with the base's bits 2:0 discarded.
- R6: An unmasked, unblocked secondary request produces rising edges on primary line 2. Primary line 2 is always edge-triggered, and the external m_lines[2] pin has no effect.
- R7: When the primary winner is line 2, the secondary is acknowledged too, and the vector uses s_base and the secondary winner. If the secondary has no winner, the vector uses s_base and line 7, and the secondary state is left unchanged.
- R8: An acknowledge while the primary has no winner returns m_base with line 7, and no request or in-service bit changes.
- R9: With automatic end-of-interrupt on, an acknowledged line is left out of service. If rotate-on-auto-EOI is also on, that controller's rotation base becomes the line plus 1, modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_lines | input | 8 | Primary request lines (bit 2 unused) |
| s_lines | input | 8 | Secondary request lines |
| m_mask | input | 8 | Primary per-line mask, 1 = masked |
| s_mask | input | 8 | Secondary per-line mask, 1 = masked |
| m_level_trig | input | 8 | Primary trigger mode, 1 = level, 0 = edge |
| s_level_trig | input | 8 | Secondary trigger mode, 1 = level, 0 = edge |
| m_base | input | 8 | Primary vector base |
| s_base | input | 8 | Secondary vector base |
| m_auto_eoi | input | 1 | Primary automatic end-of-interrupt |
| s_auto_eoi | input | 1 | Secondary automatic end-of-interrupt |
| m_rot_aeoi | input | 1 | Primary rotate on automatic end-of-interrupt |
| s_rot_aeoi | input | 1 | Secondary rotate on automatic end-of-interrupt |
| ack_req | input | 1 | Acknowledge strobe, one acknowledge per cycle high |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | Vector valid, one cycle after the strobe |
| ack_vector | output | 8 | Returned vector |
| m_isr | output | 8 | Primary in-service bits |
| s_isr | output | 8 | Secondary in-service bits |
| m_irr | output | 8 | Primary request bits |
| s_irr | output | 8 | Secondary request bits |

## Verification
The assertions assume that ack_req is a plain synchronous strobe and that the mode flags and bases hold steady across the cycle following a strobe. The in-service growth check further assumes automatic end-of-interrupt is off while it applies. The stimulus changes mode flags only between scenarios, with reset in between or with no strobe pending, and it drives every input on the falling edge. Random phases run both controllers in rotating automatic end-of-interrupt mode, so in-service stays empty. Expected vectors then follow from the request and mask bits visible at the ports together with the rotation the bench tracks itself.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned LINES    = 8;
  localparam int unsigned LW       = $clog2(LINES);
  localparam int unsigned VEC_W    = 8;
  localparam int unsigned CAS_LINE = 2;
  localparam int unsigned SPUR     = LINES - 1;

  typedef logic [LINES-1:0] line_vec_t;
  typedef logic [LW-1:0]    line_idx_t;
  typedef logic [VEC_W-1:0] vector_t;
endpackage

// File: rtl/irqc_req_latch.sv
module irqc_req_latch
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t lines,
  input  line_vec_t level_trig,
  input  line_vec_t clr,
  output line_vec_t irr
);
  line_vec_t prev_q, irr_q, irr_d;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_comb begin
      if (level_trig[i])
        irr_d[i] = lines[i];
      else if (clr[i])
        irr_d[i] = 1'b0;
      else if (lines[i] && !prev_q[i])
        irr_d[i] = 1'b1;
      else
        irr_d[i] = irr_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= lines;
      irr_q  <= irr_d;
    end
  end

  assign irr = irr_q;
endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
  import irqc_pkg::*;
(
  input  line_vec_t irr,
  input  line_vec_t imr,
  input  line_vec_t isr,
  input  line_idx_t rot_base,
  output logic      req,
  output line_idx_t line
);
  logic [LW:0] pend_off, svc_off;
  line_vec_t   pend;
  line_idx_t   pend_line;

  assign pend = irr & ~imr;

  always_comb begin
    pend_off  = (LW+1)'(LINES);
    svc_off   = (LW+1)'(LINES);
    pend_line = '0;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (pend[LW'(rot_base + LW'(k))]) begin
        pend_off  = (LW+1)'(k);
        pend_line = LW'(rot_base + LW'(k));
      end
      if (isr[LW'(rot_base + LW'(k))])
        svc_off = (LW+1)'(k);
    end
  end

  assign req  = (pend_off != (LW+1)'(LINES)) && (pend_off < svc_off);
  assign line = pend_line;
endmodule

// File: rtl/irqc_cascade_ack.sv
module irqc_cascade_ack
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] m_lines,
  input  logic [7:0] s_lines,
  input  logic [7:0] m_mask,
  input  logic [7:0] s_mask,
  input  logic [7:0] m_level_trig,
  input  logic [7:0] s_level_trig,
  input  logic [7:0] m_base,
  input  logic [7:0] s_base,
  input  logic       m_auto_eoi,
  input  logic       s_auto_eoi,
  input  logic       m_rot_aeoi,
  input  logic       s_rot_aeoi,
  input  logic       ack_req,
  output logic       cpu_int,
  output logic       ack_valid,
  output logic [7:0] ack_vector,
  output logic [7:0] m_isr,
  output logic [7:0] s_isr,
  output logic [7:0] m_irr,
  output logic [7:0] s_irr
);
  localparam line_vec_t CAS_BIT  = line_vec_t'(1) << CAS_LINE;
  localparam line_idx_t CAS_IDX  = line_idx_t'(CAS_LINE);
  localparam line_idx_t SPUR_IDX = line_idx_t'(SPUR);

  // state
  line_vec_t m_isr_q, m_isr_d, s_isr_q, s_isr_d;
  line_idx_t m_rot_q, m_rot_d, s_rot_q, s_rot_d;
  logic      cas_q, cas_d;
  logic      vld_q;
  vector_t   vec_q, vec_d;

  // request latches and resolvers
  line_vec_t m_irr_w, s_irr_w, m_clr, s_clr, m_lines_eff, m_trig_eff;
  logic      m_req, s_req;
  line_idx_t m_line, s_line;

  assign m_lines_eff = (m_lines & ~CAS_BIT) | (cas_q ? CAS_BIT : '0);
  assign m_trig_eff  = m_level_trig & ~CAS_BIT;

  irqc_req_latch u_m_latch (
    .clk(clk), .rst_n(rst_n), .lines(m_lines_eff), .level_trig(m_trig_eff),
    .clr(m_clr), .irr(m_irr_w)
  );
  irqc_req_latch u_s_latch (
    .clk(clk), .rst_n(rst_n), .lines(s_lines), .level_trig(s_level_trig),
    .clr(s_clr), .irr(s_irr_w)
  );
  irqc_resolver u_m_res (
    .irr(m_irr_w), .imr(m_mask), .isr(m_isr_q), .rot_base(m_rot_q),
    .req(m_req), .line(m_line)
  );
  irqc_resolver u_s_res (
    .irr(s_irr_w), .imr(s_mask), .isr(s_isr_q), .rot_base(s_rot_q),
    .req(s_req), .line(s_line)
  );

  // next state
  always_comb begin
    m_isr_d = m_isr_q;
    s_isr_d = s_isr_q;
    m_rot_d = m_rot_q;
    s_rot_d = s_rot_q;
    m_clr   = '0;
    s_clr   = '0;
    vec_d   = {m_base[VEC_W-1:LW], SPUR_IDX};
    cas_d   = s_req && !cas_q && !ack_req;
    if (ack_req && m_req) begin
      if (!m_auto_eoi)
        m_isr_d[m_line] = 1'b1;
      else if (m_rot_aeoi)
        m_rot_d = m_line + 1'b1;
      m_clr[m_line] = !m_trig_eff[m_line];
      if (m_line == CAS_IDX) begin
        vec_d = {s_base[VEC_W-1:LW], SPUR_IDX};
        if (s_req) begin
          if (!s_auto_eoi)
            s_isr_d[s_line] = 1'b1;
          else if (s_rot_aeoi)
            s_rot_d = s_line + 1'b1;
          s_clr[s_line] = !s_level_trig[s_line];
          vec_d = {s_base[VEC_W-1:LW], s_line};
        end
      end else begin
        vec_d = {m_base[VEC_W-1:LW], m_line};
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_isr_q <= '0;
      s_isr_q <= '0;
      m_rot_q <= '0;
      s_rot_q <= '0;
      cas_q   <= 1'b0;
      vld_q   <= 1'b0;
      vec_q   <= '0;
    end else begin
      cas_q <= cas_d;
      vld_q <= ack_req;
      if (ack_req) begin
        m_isr_q <= m_isr_d;
        s_isr_q <= s_isr_d;
        m_rot_q <= m_rot_d;
        s_rot_q <= s_rot_d;
        vec_q   <= vec_d;
      end
    end
  end

  assign cpu_int    = m_req;
  assign ack_valid  = vld_q;
  assign ack_vector = vec_q;
  assign m_isr      = m_isr_q;
  assign s_isr      = s_isr_q;
  assign m_irr      = m_irr_w;
  assign s_irr      = s_irr_w;
endmodule

// File: rtl/irqc_cascade_ack_chk.sv
module irqc_cascade_ack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] m_lines,
  input logic [7:0] s_lines,
  input logic [7:0] m_mask,
  input logic [7:0] s_mask,
  input logic [7:0] m_level_trig,
  input logic [7:0] s_level_trig,
  input logic [7:0] m_base,
  input logic [7:0] s_base,
  input logic       m_auto_eoi,
  input logic       s_auto_eoi,
  input logic       m_rot_aeoi,
  input logic       s_rot_aeoi,
  input logic       ack_req,
  input logic       cpu_int,
  input logic       ack_valid,
  input logic [7:0] ack_vector,
  input logic [7:0] m_isr,
  input logic [7:0] s_isr,
  input logic [7:0] m_irr,
  input logic [7:0] s_irr
);
  p_valid_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> ack_valid);

  p_valid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_req |=> !ack_valid);

  p_int_needs_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_int |-> ((m_irr & ~m_mask) != 8'h00));

  p_isr_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && cpu_int && !m_auto_eoi) |=>
      ($countones(m_isr) == $countones($past(m_isr)) + 1));

  p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !cpu_int) |=>
      (ack_vector == {$past(m_base[7:3]), 3'd7}) && $stable(m_isr) && $stable(s_isr));

  p_aeoi_no_service_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && m_auto_eoi) |=> $stable(m_isr));
endmodule

bind irqc_cascade_ack irqc_cascade_ack_chk u_chk (.*);

// File: tb/irqc_cascade_ack_bench.sv
`timescale 1ns/1ps
module irqc_cascade_ack_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] m_lines, s_lines, m_mask, s_mask, m_level_trig, s_level_trig;
  logic [7:0] m_base, s_base;
  logic       m_auto_eoi, s_auto_eoi, m_rot_aeoi, s_rot_aeoi, ack_req;
  logic       cpu_int, ack_valid;
  logic [7:0] ack_vector, m_isr, s_isr, m_irr, s_irr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  irqc_cascade_ack u_irqc_cascade_ack (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_lines = '0; s_lines = '0; m_mask = '0; s_mask = '0;
    m_level_trig = '0; s_level_trig = '0;
    ack_req = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic ack();
    ack_req = 1'b1;
    tick(1);
    ack_req = 1'b0;
  endtask

  // highest-priority set bit of pend starting from rot; -1 if none
  function automatic int pick(input logic [7:0] pend, input int rot);
    for (int k = 0; k < 8; k++)
      if (pend[(rot + k) % 8]) return (rot + k) % 8;
    return -1;
  endfunction

  initial begin
    m_base = 8'h47; s_base = 8'h75;
    m_auto_eoi = 0; s_auto_eoi = 0; m_rot_aeoi = 0; s_rot_aeoi = 0;
    do_reset();

    // R1 reset state
    check(cpu_int == 0 && ack_valid == 0 && ack_vector == 0, "R1", "outputs", {cpu_int, ack_valid, ack_vector}, 0);
    check({m_irr, s_irr, m_isr, s_isr} == 0, "R1", "state", int'({m_irr, s_irr}), 0);

    // R2/R4/R5 edge line 5 on primary, base low bits dropped
    m_lines = 8'h20; tick(4);
    check(cpu_int == 1 && m_irr == 8'h20, "R2", "edge latch", m_irr, 8'h20);
    ack();
    check(ack_valid == 1 && ack_vector == 8'h45, "R5", "vector", ack_vector, 8'h45);
    check(m_isr == 8'h20 && m_irr == 8'h00, "R4", "edge isr/irr", {m_isr, m_irr}, 16'h2000);
    tick(1);
    check(ack_valid == 0, "R4", "valid one cycle", ack_valid, 0);

    // R3 in-service blocks lower priority, higher still passes
    do_reset();
    m_lines = 8'h08; tick(4); ack();
    m_lines = 8'h28; tick(4);
    check(cpu_int == 0, "R3", "lower blocked", cpu_int, 0);
    m_lines = 8'h2A; tick(4);
    check(cpu_int == 1, "R3", "higher passes", cpu_int, 1);
    ack();
    check(ack_vector == 8'h41 && m_isr == 8'h0A, "R3", "nested ack", {ack_vector, m_isr}, 16'h410A);

    // R2 mask keeps latching but hides line
    do_reset();
    m_mask = 8'h10; m_lines = 8'h10; tick(4);
    check(m_irr == 8'h10 && cpu_int == 0, "R2", "masked", {m_irr, 7'd0, cpu_int}, 16'h1000);

    // R4 level line keeps its request bit
    do_reset();
    m_level_trig = 8'h10; m_lines = 8'h10; tick(3); ack();
    check(ack_vector == 8'h44 && m_isr == 8'h10 && m_irr == 8'h10, "R4", "level ack", {m_isr, m_irr}, 16'h1010);
    m_lines = 8'h00; tick(2);
    check(m_irr == 8'h00, "R2", "level follows", m_irr, 0);

    // R8 spurious primary
    do_reset();
    ack();
    check(ack_vector == 8'h47 && m_isr == 0 && s_isr == 0, "R8", "spurious", ack_vector, 8'h47);

    // R6 external pin 2 ignored
    m_lines = 8'h04; tick(4);
    check(m_irr == 0 && cpu_int == 0, "R6", "pin2 ignored", m_irr, 0);

    // R6/R7 secondary request through cascade
    do_reset();
    s_lines = 8'h08; tick(6);
    check(m_irr == 8'h04 && cpu_int == 1, "R6", "cascade edge", m_irr, 8'h04);
    ack();
    check(ack_vector == 8'h73, "R7", "secondary vector", ack_vector, 8'h73);
    check(m_isr == 8'h04 && s_isr == 8'h08 && s_irr == 0, "R7", "both in service", {m_isr, s_isr}, 16'h0408);
    tick(6);
    check(m_irr == 8'h00, "R6", "no stray cascade", m_irr, 0);

    // R7 secondary spurious
    do_reset();
    s_level_trig = 8'h08; s_lines = 8'h08; tick(6);
    s_lines = 8'h00; tick(3);
    check(m_irr == 8'h04 && s_irr == 0, "R7", "setup", {m_irr, s_irr}, 16'h0400);
    ack();
    check(ack_vector == 8'h77 && m_isr == 8'h04 && s_isr == 0, "R7", "secondary spurious", ack_vector, 8'h77);

    // R9 auto-EOI with rotation
    do_reset();
    m_auto_eoi = 1; m_rot_aeoi = 1;
    m_lines = 8'h0A; tick(4); ack();
    check(ack_vector == 8'h41 && m_isr == 0, "R9", "aeoi first", ack_vector, 8'h41);
    m_lines = 8'h0B; tick(4); ack();
    check(ack_vector == 8'h43, "R9", "rotated order", ack_vector, 8'h43);

    // R9 auto-EOI without rotation
    do_reset();
    m_rot_aeoi = 0;
    m_lines = 8'h0A; tick(4); ack();
    m_lines = 8'h0B; tick(4); ack();
    check(ack_vector == 8'h40 && m_isr == 0, "R9", "fixed order", ack_vector, 8'h40);

    // random phase: rotating auto-EOI on both
    begin
      int mrot, srot, ml, sl;
      logic [7:0] exp_vec;
      void'($urandom(32'd20240611));
      do_reset();
      m_auto_eoi = 1; s_auto_eoi = 1; m_rot_aeoi = 1; s_rot_aeoi = 1;
      mrot = 0; srot = 0;
      for (int it = 0; it < 80; it++) begin
        m_lines = 8'($urandom); s_lines = 8'($urandom);
        m_mask  = 8'($urandom & $urandom & $urandom);
        s_mask  = 8'($urandom & $urandom & $urandom);
        m_base  = 8'($urandom); s_base = 8'($urandom);
        tick(5);
        ml = pick(m_irr & ~m_mask, mrot);
        check(cpu_int == (ml >= 0), "R3", "random int", cpu_int, ml >= 0);
        if (ml < 0) exp_vec = {m_base[7:3], 3'd7};
        else if (ml == 2) begin
          sl = pick(s_irr & ~s_mask, srot);
          if (sl < 0) exp_vec = {s_base[7:3], 3'd7};
          else begin exp_vec = {s_base[7:3], 3'(sl)}; srot = (sl + 1) % 8; end
        end else exp_vec = {m_base[7:3], 3'(ml)};
        if (ml >= 0) mrot = (ml + 1) % 8;
        ack();
        check(ack_valid == 1 && ack_vector == exp_vec, "R7", "random vector", ack_vector, exp_vec);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule